// File: doc/BRIEF.md
# Handshake Channel Buffer

This block is a first-in first-out channel buffer that sits between a producing process and a consuming process. Its storage is a small dual-port memory: one port only ever writes and the other only ever reads. A write address counter and a read address counter move independently, and the distance between them gives the number of items held. That count separates a full buffer from an empty one.

Neither side uses a simple enable. The producer offers an item with a request and waits for an acknowledge. The buffer gives that acknowledge only when it has room. On the other side, the buffer raises its own request toward the consumer whenever it holds an item, and the consumer answers with an acknowledge. Each side runs a three-state exchange, so a responsive partner moves one item every three clock cycles on each side. The write side and the read side run concurrently, and a store and a fetch in the same cycle leave the count unchanged.

`DEPTH` must be a power of two. Both the width and the depth are parameters.

Top module: `hs_chan_buf`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `put_ack` and `get_req` are both 0.
- R2: `put_ack` rises only in response to a high `put_req` while fewer than `DEPTH` items are held. A request made while the buffer is full receives no acknowledge until an item has been taken out.
- R3: Once raised, `put_ack` stays high for as long as `put_req` stays high. It falls on the first clock edge at which `put_req` is seen low.
- R4: `get_req` rises only when at least one item is held. With the buffer empty, `get_req` stays 0.
- R5: Items leave in the order they were accepted, and each item's bits are unchanged. While `get_req` is high and `get_ack` is low, `get_data` and `get_req` hold steady.
- R6: When `get_ack` is seen high with `get_req` high, `get_req` drops at the next edge. It stays low for at least two cycles, and for as long as `get_ack` remains high.
- R7: The buffer accepts exactly `DEPTH` items with no reads in between. The count it holds never exceeds `DEPTH`.
- R8: Stores and fetches may overlap in time. Under interleaved traffic every accepted item is delivered exactly once.
- R9: With a partner that answers on the next cycle, successive `put_ack` rises are 3 cycles apart, and so are successive item handovers on the read side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| put_req | input | 1 | Producer offers the item on `put_data` |
| put_data | input | DATA_W | Item offered by the producer |
| put_ack | output | 1 | Item accepted; held until `put_req` falls |
| get_req | output | 1 | Buffer offers the item on `get_data` |
| get_data | output | DATA_W | Oldest held item |
| get_ack | input | 1 | Consumer has taken the offered item |

## Verification
The assertions check the handshake rules on every cycle. They cover an acknowledge that never rises on a full buffer, an offer that never rises on an empty one, an acknowledge held with its request, offered data held until taken, the two-cycle gap after a handover, and a count bounded by `DEPTH`. Only the bench scenarios can show that data arrives in order and complete under overlapping traffic. The same holds for the exact capacity, the release of a blocked producer once space appears, and the three-cycle spacing of transfers.

// File: rtl/hs_chan_buf.sv
module hs_chan_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put_req,
  input  logic [DATA_W-1:0] put_data,
  output logic              put_ack,
  output logic              get_req,
  output logic [DATA_W-1:0] get_data,
  input  logic              get_ack
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {P_IDLE, P_HOLD, P_REST} put_st_t;
  typedef enum logic [1:0] {G_IDLE, G_OFFER, G_GAP} get_st_t;

  put_st_t put_st;
  get_st_t get_st;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr, level;
  logic        store, fetch_ld, taken;

  assign level    = wptr - rptr;
  assign store    = (put_st == P_IDLE) && put_req && (level != FULL_LVL);
  assign fetch_ld = (get_st == G_IDLE) && (level != '0);
  assign taken    = (get_st == G_OFFER) && get_ack;

  always_ff @(posedge clk) begin
    if (store) mem[wptr[AW-1:0]] <= put_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_st  <= P_IDLE;
      put_ack <= 1'b0;
      wptr    <= '0;
    end else begin
      case (put_st)
        P_IDLE: if (store) begin
          put_ack <= 1'b1;
          wptr    <= wptr + 1'b1;
          put_st  <= P_HOLD;
        end
        P_HOLD: if (!put_req) begin
          put_ack <= 1'b0;
          put_st  <= P_REST;
        end
        default: put_st <= P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      get_st   <= G_IDLE;
      get_req  <= 1'b0;
      get_data <= '0;
      rptr     <= '0;
    end else begin
      case (get_st)
        G_IDLE: if (fetch_ld) begin
          get_data <= mem[rptr[AW-1:0]];
          get_req  <= 1'b1;
          get_st   <= G_OFFER;
        end
        G_OFFER: if (taken) begin
          get_req <= 1'b0;
          rptr    <= rptr + 1'b1;
          get_st  <= G_GAP;
        end
        default: if (!get_ack) get_st <= G_IDLE;
      endcase
    end
  end
endmodule

module hs_chan_buf_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              put_req,
  input logic              put_ack,
  input logic              get_req,
  input logic              get_ack,
  input logic [DATA_W-1:0] get_data,
  input logic [AW:0]       level
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !put_ack && !get_req);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(put_ack) |-> $past(put_req) && ($past(level) < (AW+1)'(DEPTH)));
  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    put_ack && put_req |=> put_ack);
  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    put_ack && !put_req |=> !put_ack);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(get_req) |-> $past(level) != '0);
  // R5
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    get_req && !get_ack |=> get_req && $stable(get_data));
  // R6
  offer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    get_req && get_ack |=> !get_req);
  // R6
  offer_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(get_req) |=> !get_req);
  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
endmodule

bind hs_chan_buf hs_chan_buf_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)
) i_hs_chan_buf_chk (
  .clk(clk), .rst_n(rst_n), .put_req(put_req), .put_ack(put_ack),
  .get_req(get_req), .get_ack(get_ack), .get_data(get_data), .level(level)
);

// File: tb/test_hs_chan_buf.sv
module test_hs_chan_buf;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic put_req = 1'b0;
  logic [DATA_W-1:0] put_data = '0;
  logic put_ack;
  logic get_req;
  logic [DATA_W-1:0] get_data;
  logic get_ack = 1'b0;

  always #2.5 clk = ~clk;

  hs_chan_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_hs_chan_buf (
    .clk(clk), .rst_n(rst_n), .put_req(put_req), .put_data(put_data),
    .put_ack(put_ack), .get_req(get_req), .get_data(get_data), .get_ack(get_ack)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [DATA_W-1:0] expq[$];
  int pushed = 0, popped = 0;
  bit cons_en = 0;
  int cons_hold = 0;
  int hold_left = 0;
  bit meas_put = 0, meas_get = 0;
  int last_put = -1, last_get = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic put_item(input logic [DATA_W-1:0] d, input int extra);
    put_data = d;
    put_req  = 1'b1;
    do @(negedge clk); while (!put_ack);
    expq.push_back(d);
    pushed++;
    if (meas_put && last_put >= 0) chk(cyc - last_put == 3, "R9 put spacing", cyc - last_put, 3);
    last_put = cyc;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      chk(put_ack == 1'b1, "R3 ack held", put_ack, 1);
    end
    put_req = 1'b0;
    @(negedge clk);
    chk(put_ack == 1'b0, "R3 ack release", put_ack, 0);
  endtask

  // Consumer / monitor
  initial begin
    forever begin
      @(negedge clk);
      if (get_ack) begin
        if (get_req) begin
          chk(0, "R6 req drop", 1, 0);
        end else if (hold_left > 0) begin
          hold_left--;
        end else begin
          get_ack = 1'b0;
        end
      end else if (cons_en && get_req) begin
        if (expq.size() == 0) begin
          chk(0, "R4 offer with nothing expected", 1, 0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expq.pop_front();
          chk(get_data == e, "R5 data order", get_data, e);
        end
        popped++;
        if (meas_get && last_get >= 0) chk(cyc - last_get == 3, "R9 get spacing", cyc - last_get, 3);
        last_get = cyc;
        get_ack = 1'b1;
        hold_left = cons_hold;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic drain();
    while (expq.size() != 0 || get_req || get_ack) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(put_ack == 0, "R1 put_ack in reset", put_ack, 0);
    chk(get_req == 0, "R1 get_req in reset", get_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(put_ack == 0 && get_req == 0, "R1 after reset", {put_ack, get_req}, 0);

    // R4 empty idle
    repeat (5) @(negedge clk);
    chk(get_req == 0, "R4 empty no offer", get_req, 0);

    // R7 + R9: fill with consumer off
    meas_put = 1;
    for (int i = 0; i < DEPTH; i++) put_item(16'h1000 + 16'(i), 0);
    meas_put = 0;
    chk(get_req == 1, "R4 offer when held", get_req, 1);
    // R2/R7 blocked request
    put_data = 16'hBEEF;
    put_req  = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(put_ack == 0, "R2 R7 no ack when full", put_ack, 0);
    end
    chk(popped == 0, "R7 nothing taken", popped, 0);
    // release
    meas_get = 1;
    cons_en  = 1;
    while (!put_ack) @(negedge clk);
    expq.push_back(16'hBEEF);
    pushed++;
    put_req = 1'b0;
    @(negedge clk);
    chk(popped >= 1, "R2 released after read", popped, 1);
    drain();
    meas_get = 0;
    last_get = -1;
    chk(popped == DEPTH + 1, "R7 all delivered", popped, DEPTH + 1);

    // R4 empty after drain
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(get_req == 0, "R4 empty after drain", get_req, 0);
    end

    // R3 extended request
    put_item(16'h5A5A, 4);
    drain();

    // R6 slow consumer ack
    cons_hold = 3;
    put_item(16'h0F0F, 0);
    put_item(16'hF0F0, 0);
    drain();
    cons_hold = 0;

    // R8 overlapping traffic
    for (int i = 0; i < 40; i++) put_item(16'((i * 16'd37) ^ 16'hA5C3), i % 3);
    drain();
    chk(popped == pushed, "R8 all items delivered once", popped, pushed);
    chk(expq.size() == 0, "R8 scoreboard empty", expq.size(), 0);

    finish_run();
  end
endmodule